// File: doc/BRIEF.md
# DMA Command-Queue Register Block

This block is the software-facing register file of a DMA engine's command queue. It keeps a queue end pointer and a write pointer, both 18 bits wide, and a read pointer that always takes the value of the write pointer. It also holds an interrupt enable register, an interrupt status register and a set of general-purpose 32-bit words. Software posts work by writing the write pointer. That write at once counts as completion in both directions: the upstream and downstream completion status bits are set, and a level interrupt is raised if the enable register allows it.

A fixed key value written to the read-pointer register arms a one-shot. The next write-pointer update is then taken silently, with no completion. Completion bits are cleared by writing a one to either of them in the status register. The interrupt line stays high until that clear happens.

Access is through a plain word-wide register port: byte address, write strobe, write data, and read data registered one cycle later. A parameter selects one of two register layouts, which differ in offsets, completion bit positions and enable mask. Data movement and descriptor handling are outside this block.

Top module: `dma_cmdq_regs`

## Requirements
- R1: After reset every word reads 0, except the status word, which reads 0xF8000000. The interrupt output is low and the one-shot is disarmed.
- R2: A write to the end-pointer word stores only wdata[17:0]; bits 31:18 read back as 0.
- R3: A write to the write-pointer word stores wdata[17:0] there and loads the same value into the read-pointer word, both visible from the next cycle.
- R4: Writing exactly 0xEE882266 to the read-pointer word arms the one-shot. Any write to the read-pointer word leaves its stored value unchanged, and any other value does not arm the one-shot.
- R5: A write-pointer write while armed disarms the one-shot and leaves the status word and the interrupt unchanged.
- R6: A write-pointer write while disarmed sets both completion bits (bits 4 and 5 in layout A, bits 16 and 17 in layout B). If the enable word has either of these bits set, irq_o is high from the next cycle.
- R7: A status write with either completion bit set clears both bits and drops irq_o in the next cycle. Status writes never change any other status bit.
- R8: Enable-word writes are masked: 0xBFEFF07F in layout A, 0x017003FF in layout B. Layout B therefore can never enable completion, and its irq_o stays low.
- R9: Layout A (VARIANT=0) places end, write pointer, read pointer, enable and status at byte offsets 0x14, 0x18, 0x1C, 0x20 and 0x24. Layout B (VARIANT=1) places them at 0x18, 0x1C, 0x20, 0x38 and 0x3C.
- R10: Every other word in the 32-word space stores all 32 bits. rdata_o shows the word addressed in the previous cycle, as it stood before any write in that cycle.
- R11: Addresses at or above 0x80 read 0 and ignore writes. Address bits 1:0 are ignored.
- R12: Once high, irq_o stays high until a completion clear, even if the enable word is later cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | BUS_AW (12) | Byte address of the access |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Level completion interrupt |

## Verification
The bench instantiates the block twice: once with VARIANT=0 and once with VARIANT=1, each with its own bus and its own reference model. The layout A instance covers the interrupt path, including arm, suppress and re-raise. The layout B instance shows that the same offsets become plain storage, that the completion bits move to 16 and 17, and that the enable mask keeps the interrupt silent. Out-of-range and sub-word addresses use the default 12-bit bus, so the region above the 128-byte register space is reachable.

// File: rtl/dma_cmdq_pkg.sv
package dma_cmdq_pkg;

  typedef enum logic [2:0] {
    K_PLAIN,
    K_END,
    K_WP,
    K_RP,
    K_CTRL,
    K_STAT
  } word_kind_e;

  localparam logic [31:0] ARM_KEY  = 32'hEE88_2266;
  localparam logic [31:0] STAT_RST = 32'hF800_0000;

  function automatic int unsigned end_off(int unsigned v);
    return (v == 0) ? 32'h14 : 32'h18;
  endfunction

  function automatic int unsigned wp_off(int unsigned v);
    return (v == 0) ? 32'h18 : 32'h1C;
  endfunction

  function automatic int unsigned rp_off(int unsigned v);
    return (v == 0) ? 32'h1C : 32'h20;
  endfunction

  function automatic int unsigned ctrl_off(int unsigned v);
    return (v == 0) ? 32'h20 : 32'h38;
  endfunction

  function automatic int unsigned stat_off(int unsigned v);
    return (v == 0) ? 32'h24 : 32'h3C;
  endfunction

  function automatic logic [31:0] ctrl_mask(int unsigned v);
    return (v == 0) ? 32'hBFEF_F07F : 32'h0170_03FF;
  endfunction

  function automatic logic [31:0] cmp_mask(int unsigned v);
    return (v == 0) ? 32'h0000_0030 : 32'h0003_0000;
  endfunction

  function automatic word_kind_e kind_of(int unsigned v, int unsigned idx);
    int unsigned b;
    b = idx * 4;
    if (b == end_off(v))  return K_END;
    if (b == wp_off(v))   return K_WP;
    if (b == rp_off(v))   return K_RP;
    if (b == ctrl_off(v)) return K_CTRL;
    if (b == stat_off(v)) return K_STAT;
    return K_PLAIN;
  endfunction

endpackage

// File: rtl/dma_cmdq_decode.sv
module dma_cmdq_decode
  import dma_cmdq_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned BUS_AW  = 12,
  parameter int unsigned WORDS   = 32,
  localparam int unsigned IDX_W  = $clog2(WORDS)
) (
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              we_i,
  output logic              in_range_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORDS-1:0]  wr_vec_o,
  output logic              wr_wp_o,
  output logic              wr_rp_o,
  output logic              wr_stat_o
);
  localparam int unsigned WP_IDX   = wp_off(VARIANT) / 4;
  localparam int unsigned RP_IDX   = rp_off(VARIANT) / 4;
  localparam int unsigned STAT_IDX = stat_off(VARIANT) / 4;

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign idx_o      = addr_i[IDX_W+1:2];
  assign in_range_o = (addr_i[BUS_AW-1:IDX_W+2] == '0);

  for (genvar i = 0; i < WORDS; i++) begin : g_sel
    assign wr_vec_o[i] = we_i && in_range_o && (idx_o == IDX_W'(i));
  end

  assign wr_wp_o   = wr_vec_o[WP_IDX];
  assign wr_rp_o   = wr_vec_o[RP_IDX];
  assign wr_stat_o = wr_vec_o[STAT_IDX];

endmodule

// File: rtl/dma_cmdq_regfile.sv
module dma_cmdq_regfile
  import dma_cmdq_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned WORDS   = 32,
  parameter int unsigned PTR_W   = 18
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [WORDS-1:0]       wr_vec_i,
  input  logic                   wr_wp_i,
  input  logic [31:0]            wdata_i,
  input  logic                   set_cmp_i,
  input  logic                   clr_cmp_i,
  output logic [WORDS-1:0][31:0] regs_o,
  output logic [31:0]            ctrl_o
);
  localparam logic [31:0] PTR_MASK = {{(32-PTR_W){1'b0}}, {PTR_W{1'b1}}};
  localparam logic [31:0] CMASK    = ctrl_mask(VARIANT);
  localparam logic [31:0] CMP      = cmp_mask(VARIANT);
  localparam int unsigned CTRL_IDX = ctrl_off(VARIANT) / 4;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam word_kind_e KIND = kind_of(VARIANT, i);
    logic [31:0] q;

    if (KIND == K_STAT) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= STAT_RST;
        else if (set_cmp_i) q <= q | CMP;
        else if (clr_cmp_i) q <= q & ~CMP;
      end
    end else if (KIND == K_RP) begin : g_rp
      // mirrors write pointer; own writes only feed the arm logic
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (wr_wp_i) q <= wdata_i & PTR_MASK;
      end
    end else if (KIND == K_END || KIND == K_WP) begin : g_ptr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= '0;
        else if (wr_vec_i[i]) q <= wdata_i & PTR_MASK;
      end
    end else if (KIND == K_CTRL) begin : g_ctrl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= '0;
        else if (wr_vec_i[i]) q <= wdata_i & CMASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= '0;
        else if (wr_vec_i[i]) q <= wdata_i;
      end
    end

    assign regs_o[i] = q;
  end

  assign ctrl_o = regs_o[CTRL_IDX];

endmodule

// File: rtl/dma_cmdq_irq.sv
module dma_cmdq_irq
  import dma_cmdq_pkg::*;
#(
  parameter int unsigned VARIANT = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_wp_i,
  input  logic        wr_rp_i,
  input  logic        wr_stat_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] ctrl_i,
  output logic        set_cmp_o,
  output logic        clr_cmp_o,
  output logic        armed_o,
  output logic        irq_o
);
  localparam logic [31:0] CMP = cmp_mask(VARIANT);

  logic armed_q, irq_q;

  assign set_cmp_o = wr_wp_i && !armed_q;
  assign clr_cmp_o = wr_stat_i && ((wdata_i & CMP) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                armed_q <= 1'b0;
    else if (wr_wp_i)                           armed_q <= 1'b0;
    else if (wr_rp_i && (wdata_i == ARM_KEY))   armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     irq_q <= 1'b0;
    else if (set_cmp_o && ((ctrl_i & CMP) != '0))   irq_q <= 1'b1;
    else if (clr_cmp_o)                              irq_q <= 1'b0;
  end

  assign armed_o = armed_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/dma_cmdq_regs.sv
module dma_cmdq_regs
  import dma_cmdq_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned BUS_AW  = 12,
  parameter int unsigned WORDS   = 32,
  parameter int unsigned PTR_W   = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic                   in_range;
  logic [IDX_W-1:0]       idx;
  logic [WORDS-1:0]       wr_vec;
  logic                   wr_wp, wr_rp, wr_stat;
  logic                   set_cmp, clr_cmp, armed;
  logic [WORDS-1:0][31:0] regs;
  logic [31:0]            ctrl;
  logic [31:0]            rdata_q;

  dma_cmdq_decode #(
    .VARIANT(VARIANT), .BUS_AW(BUS_AW), .WORDS(WORDS)
  ) u_dec (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .in_range_o(in_range),
    .idx_o     (idx),
    .wr_vec_o  (wr_vec),
    .wr_wp_o   (wr_wp),
    .wr_rp_o   (wr_rp),
    .wr_stat_o (wr_stat)
  );

  dma_cmdq_regfile #(
    .VARIANT(VARIANT), .WORDS(WORDS), .PTR_W(PTR_W)
  ) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_vec_i (wr_vec),
    .wr_wp_i  (wr_wp),
    .wdata_i  (wdata_i),
    .set_cmp_i(set_cmp),
    .clr_cmp_i(clr_cmp),
    .regs_o   (regs),
    .ctrl_o   (ctrl)
  );

  dma_cmdq_irq #(
    .VARIANT(VARIANT)
  ) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_wp_i  (wr_wp),
    .wr_rp_i  (wr_rp),
    .wr_stat_i(wr_stat),
    .wdata_i  (wdata_i),
    .ctrl_i   (ctrl),
    .set_cmp_o(set_cmp),
    .clr_cmp_o(clr_cmp),
    .armed_o  (armed),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (in_range) rdata_q <= regs[idx];
    else               rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/dma_cmdq_chk.sv
module dma_cmdq_chk
  import dma_cmdq_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned BUS_AW  = 12,
  parameter int unsigned WORDS   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              armed_i
);
  localparam int unsigned WA = BUS_AW - 2;
  localparam logic [WA-1:0] WP_W   = WA'(wp_off(VARIANT) / 4);
  localparam logic [WA-1:0] RP_W   = WA'(rp_off(VARIANT) / 4);
  localparam logic [WA-1:0] STAT_W = WA'(stat_off(VARIANT) / 4);
  localparam logic [WA-1:0] LIM_W  = WA'(WORDS);
  localparam logic [31:0]   CMP    = cmp_mask(VARIANT);

  logic [WA-1:0] wa;
  logic hit_wp, hit_rp, hit_clr, oob;
  assign wa      = addr_i[BUS_AW-1:2];
  assign hit_wp  = we_i && (wa == WP_W);
  assign hit_rp  = we_i && (wa == RP_W);
  assign hit_clr = we_i && (wa == STAT_W) && ((wdata_i & CMP) != '0);
  assign oob     = (wa >= LIM_W);

  // R6
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hit_wp));

  // R7
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(hit_clr));

  // R11
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oob) |-> (rdata_o == '0));

  // R4
  arm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_rp && (wdata_i == ARM_KEY)) |=> armed_i);

  // R5
  arm_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && hit_wp) |=> !armed_i);

  // R5
  arm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && hit_wp && !irq_o) |=> !irq_o);

  if (VARIANT == 1) begin : g_b
    // R8
    irq_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o);
  end

endmodule

bind dma_cmdq_regs dma_cmdq_chk #(
  .VARIANT(VARIANT), .BUS_AW(BUS_AW), .WORDS(WORDS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .armed_i(armed)
);

// File: tb/dma_cmdq_regs_test.sv
module dma_cmdq_regs_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [11:0] a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  dma_cmdq_regs #(.VARIANT(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a_addr), .we_i(a_we),
    .wdata_i(a_wdata), .rdata_o(a_rdata), .irq_o(a_irq));

  dma_cmdq_regs #(.VARIANT(1)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(b_addr), .we_i(b_we),
    .wdata_i(b_wdata), .rdata_o(b_rdata), .irq_o(b_irq));

  // layout tables, index 0 = layout A, 1 = layout B
  int          off_end [2] = '{'h14, 'h18};
  int          off_wp  [2] = '{'h18, 'h1C};
  int          off_rp  [2] = '{'h1C, 'h20};
  int          off_ct  [2] = '{'h20, 'h38};
  int          off_st  [2] = '{'h24, 'h3C};
  logic [31:0] cmask   [2] = '{32'hBFEFF07F, 32'h017003FF};
  logic [31:0] cbits   [2] = '{32'h00000030, 32'h00030000};

  logic [31:0] m_regs [2][32];
  bit          m_arm  [2];
  bit          m_irq  [2];
  logic [31:0] m_rd   [2];

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic model_step(int v, logic [11:0] addr, logic we, logic [31:0] d);
    int w;
    int b;
    logic [31:0] rd;
    b  = int'(addr) & 'hFFC;
    w  = b / 4;
    rd = (b < 128) ? m_regs[v][w] : 32'h0;
    if (we && b < 128) begin
      if (b == off_end[v]) m_regs[v][w] = d & 32'h3FFFF;
      else if (b == off_wp[v]) begin
        m_regs[v][w] = d & 32'h3FFFF;
        m_regs[v][off_rp[v]/4] = d & 32'h3FFFF;
        if (m_arm[v]) m_arm[v] = 0;
        else begin
          m_regs[v][off_st[v]/4] |= cbits[v];
          if ((m_regs[v][off_ct[v]/4] & cbits[v]) != 0) m_irq[v] = 1;
        end
      end else if (b == off_rp[v]) begin
        if (d == 32'hEE882266) m_arm[v] = 1;
      end else if (b == off_ct[v]) m_regs[v][w] = d & cmask[v];
      else if (b == off_st[v]) begin
        if ((d & cbits[v]) != 0) begin
          m_regs[v][w] &= ~cbits[v];
          m_irq[v] = 0;
        end
      end else m_regs[v][w] = d;
    end
    m_rd[v] = rd;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        for (int w = 0; w < 32; w++) m_regs[v][w] = '0;
        m_regs[v][off_st[v]/4] = 32'hF8000000;
        m_arm[v] = 0;
        m_irq[v] = 0;
        m_rd[v]  = '0;
      end
    end else begin
      model_step(0, a_addr, a_we, a_wdata);
      model_step(1, b_addr, b_we, b_wdata);
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "A rdata model", a_rdata, m_rd[0]);
      check(cur_req, "A irq model", {31'b0, a_irq}, {31'b0, m_irq[0]});
      check(cur_req, "B rdata model", b_rdata, m_rd[1]);
      check(cur_req, "B irq model", {31'b0, b_irq}, {31'b0, m_irq[1]});
    end
  end

  task automatic wr(int v, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    if (v == 0) begin a_addr = a; a_wdata = d; a_we = 1'b1; end
    else        begin b_addr = a; b_wdata = d; b_we = 1'b1; end
    @(negedge clk);
    a_we = 1'b0;
    b_we = 1'b0;
  endtask

  task automatic rd_chk(int v, logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    if (v == 0) a_addr = a; else b_addr = a;
    @(negedge clk);
    check(req, $sformatf("read %0s @%03h", v == 0 ? "A" : "B", a),
          v == 0 ? a_rdata : b_rdata, exp);
  endtask

  task automatic irq_chk(int v, bit exp, string req);
    check(req, v == 0 ? "A irq" : "B irq", {31'b0, v == 0 ? a_irq : b_irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    irq_chk(0, 0, "R1");
    irq_chk(1, 0, "R1");
    rd_chk(0, 'h24, 32'hF8000000, "R1");
    rd_chk(1, 'h3C, 32'hF8000000, "R1");
    rd_chk(0, 'h18, 32'h0, "R1");
    rd_chk(1, 'h40, 32'h0, "R1");

    cur_req = "R2";
    wr(0, 'h14, 32'hFFFFFFFF);
    rd_chk(0, 'h14, 32'h0003FFFF, "R2");
    wr(1, 'h18, 32'hFFFFFFFF);
    rd_chk(1, 'h18, 32'h0003FFFF, "R2");

    cur_req = "R8";
    wr(0, 'h20, 32'hFFFFFFFF);
    rd_chk(0, 'h20, 32'hBFEFF07F, "R8");
    wr(1, 'h38, 32'hFFFFFFFF);
    rd_chk(1, 'h38, 32'h017003FF, "R8");

    cur_req = "R6";
    wr(0, 'h18, 32'h12345678);
    irq_chk(0, 1, "R6");
    rd_chk(0, 'h1C, 32'h00005678, "R3");
    rd_chk(0, 'h18, 32'h00005678, "R3");
    rd_chk(0, 'h24, 32'hF8000030, "R6");
    wr(1, 'h1C, 32'hABCDEF01);
    irq_chk(1, 0, "R8");
    rd_chk(1, 'h20, 32'h0001EF01, "R3");
    rd_chk(1, 'h3C, 32'hF8030000, "R6");

    cur_req = "R12";
    wr(0, 'h20, 32'h0);
    irq_chk(0, 1, "R12");

    cur_req = "R7";
    wr(0, 'h24, 32'hFFFFFFCF);
    irq_chk(0, 1, "R7");
    rd_chk(0, 'h24, 32'hF8000030, "R7");
    wr(0, 'h24, 32'h00000020);
    irq_chk(0, 0, "R7");
    rd_chk(0, 'h24, 32'hF8000000, "R7");
    wr(1, 'h3C, 32'h00010000);
    rd_chk(1, 'h3C, 32'hF8000000, "R7");

    cur_req = "R4";
    wr(0, 'h20, 32'h00000010);
    wr(0, 'h1C, 32'h00001234);
    rd_chk(0, 'h1C, 32'h00005678, "R4");
    wr(0, 'h18, 32'h00000055);
    irq_chk(0, 1, "R4");
    wr(0, 'h24, 32'h00000010);
    irq_chk(0, 0, "R7");
    wr(0, 'h1C, 32'hEE882266);
    rd_chk(0, 'h1C, 32'h00000055, "R4");

    cur_req = "R5";
    wr(0, 'h18, 32'h00000100);
    irq_chk(0, 0, "R5");
    rd_chk(0, 'h24, 32'hF8000000, "R5");
    rd_chk(0, 'h1C, 32'h00000100, "R3");
    wr(0, 'h18, 32'h00000200);
    irq_chk(0, 1, "R5");
    rd_chk(0, 'h24, 32'hF8000030, "R6");
    wr(0, 'h24, 32'h00000030);
    irq_chk(0, 0, "R7");

    cur_req = "R11";
    wr(0, 'h080, 32'hDEADBEEF);
    rd_chk(0, 'h080, 32'h0, "R11");
    rd_chk(0, 'h000, 32'h0, "R11");
    wr(0, 'h00B, 32'hCAFEF00D);
    rd_chk(0, 'h008, 32'hCAFEF00D, "R11");
    rd_chk(0, 'h009, 32'hCAFEF00D, "R11");
    wr(1, 'hFFC, 32'h11111111);
    rd_chk(1, 'hFFC, 32'h0, "R11");
    rd_chk(1, 'h03C, 32'hF8000000, "R11");

    cur_req = "R10";
    wr(0, 'h000, 32'hA5A55A5A);
    rd_chk(0, 'h000, 32'hA5A55A5A, "R10");
    wr(0, 'h07C, 32'h0F0F0F0F);
    rd_chk(0, 'h07C, 32'h0F0F0F0F, "R10");
    // back-to-back reads with one-cycle latency
    @(negedge clk); a_addr = 'h000;
    @(negedge clk); a_addr = 'h07C;
    check("R10", "pipelined read 0", a_rdata, 32'hA5A55A5A);
    @(negedge clk);
    check("R10", "pipelined read 1", a_rdata, 32'h0F0F0F0F);

    cur_req = "R9";
    wr(1, 'h14, 32'hFFFFFFFF);
    rd_chk(1, 'h14, 32'hFFFFFFFF, "R9");
    wr(1, 'h24, 32'h89ABCDEF);
    rd_chk(1, 'h24, 32'h89ABCDEF, "R9");
    wr(0, 'h38, 32'hFFFFFFFF);
    rd_chk(0, 'h38, 32'hFFFFFFFF, "R9");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule